// File: doc/BRIEF.md
# Port Status LED Pattern Generator

This block turns a two-bit port condition into the drive level of one status lamp. A slow, even blink tells the operator the port is hunting for a device. A steady glow means the port is feeding power. A fast blink means a fault. The fault blink is limited to a fixed window. When the window closes, the block dims the lamp and raises a one-cycle completion pulse, so the port sequencer knows when it may go back to hunting. All time is counted in ticks of a free-running 1 ms strobe. A restart strobe, which the sequencer raises whenever it changes the condition, puts every pattern back to its lit starting phase.

The half-periods and the window length are parameters given in ticks. The defaults are about 333 ms for the slow blink, 50 ms for the fast blink and 2000 ms for the fault window. A high level on the lamp output means lit.

Top module: `ledpat_gen`

## Requirements
- R1: The condition input `port_state` uses these codes: 2'b00 idle, 2'b01 hunting, 2'b10 feeding, 2'b11 fault. While the condition is idle, `led_on` is low.
- R2: While hunting, `led_on` starts high and inverts after every SLOW_HALF_MS ticks. After n ticks it is high exactly when floor(n / SLOW_HALF_MS) is even.
- R3: While feeding, `led_on` is high on every cycle, whatever the ticks do.
- R4: During the fault window, `led_on` starts high and inverts after every FAST_HALF_MS ticks.
- R5: After ERR_WINDOW_MS ticks in the fault condition, `led_on` goes low and stays low until the next restart.
- R6: `err_done` rises for exactly one cycle, in the cycle that follows the tick that ends the fault window. It rises only once per restart and only after a fault-condition window.
- R7: A `restart` strobe clears all tick counts and the fault window, and puts the blink phase back to lit. This holds when the condition code is unchanged as well.
- R8: While `rst_n` is low, `led_on` is low. After reset is released, the patterns start from the lit phase with zero ticks counted.
- R9: The lamp level changes only at a tick, a restart or a change of condition. Between ticks it holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per millisecond |
| restart | input | 1 | One-cycle strobe, raised on every change of condition |
| port_state | input | 2 | Port condition code (see R1) |
| led_on | output | 1 | Lamp drive level, high means lit |
| err_done | output | 1 | One-cycle pulse when the fault window ends |

## Verification
A tick counter that is off by one shows up as a lamp edge one tick early or late. So the lamp is sampled just before and just after each half-period boundary: ticks 6, 7, 13 and 14 for the slow pattern and ticks 2, 3 and 6 for the fast one. A fault window that ends wrongly shows up within a single tick around the twentieth: either the lamp stays lit at tick 20, or the completion pulse comes early, twice, or never. Counts left over after a restart show up on the first sample after the strobe, as a dark lamp where a lit one is expected.

// File: rtl/ledpat_pkg.sv
package ledpat_pkg;
   typedef enum logic [1:0] {
      PS_IDLE  = 2'b00,
      PS_HUNT  = 2'b01,
      PS_FEED  = 2'b10,
      PS_FAULT = 2'b11
   } port_mode_t;

   localparam int NUM_BLINKERS = 2;

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/ledpat_half_timer.sv
module ledpat_half_timer #(
   parameter int HALF = 333
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic restart,
   output logic phase
);
   localparam int CW = ledpat_pkg::cnt_width(HALF);

   if (HALF < 1) begin : g_bad_half
      $error("ledpat_half_timer: HALF must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cnt_q   <= '0;
         phase_q <= 1'b1;
      end else if (en && tick) begin
         if (cnt_q == CW'(HALF - 1)) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign phase = phase_q;
endmodule

// File: rtl/ledpat_err_window.sv
module ledpat_err_window #(
   parameter int WIN = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic restart,
   output logic active,
   output logic done
);
   localparam int CW = ledpat_pkg::cnt_width(WIN);

   if (WIN < 1) begin : g_bad_win
      $error("ledpat_err_window: WIN must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          expired_q;
   logic          done_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cnt_q     <= '0;
         expired_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (en && tick && !expired_q) begin
            if (cnt_q == CW'(WIN - 1)) begin
               expired_q <= 1'b1;
               done_q    <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign active = ~expired_q;
   assign done   = done_q;
endmodule

// File: rtl/ledpat_gen.sv
module ledpat_gen #(
   parameter int SLOW_HALF_MS  = 333,
   parameter int FAST_HALF_MS  = 50,
   parameter int ERR_WINDOW_MS = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic [1:0] port_state,
   output logic       led_on,
   output logic       err_done
);
   import ledpat_pkg::*;

   if (FAST_HALF_MS > ERR_WINDOW_MS) begin : g_bad_ratio
      $error("ledpat_gen: fast half-period longer than the fault window");
   end

   port_mode_t mode;
   logic [NUM_BLINKERS-1:0] phase;
   logic                    win_active;
   logic                    run_q;

   assign mode = port_mode_t'(port_state);

   for (genvar g = 0; g < NUM_BLINKERS; g++) begin : g_blink
      localparam int         HALF = (g == 0) ? SLOW_HALF_MS : FAST_HALF_MS;
      localparam port_mode_t OWN  = (g == 0) ? PS_HUNT : PS_FAULT;
      ledpat_half_timer #(.HALF(HALF)) u_half (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (mode == OWN),
         .tick    (tick),
         .restart (restart),
         .phase   (phase[g])
      );
   end

   ledpat_err_window #(.WIN(ERR_WINDOW_MS)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mode == PS_FAULT),
      .tick    (tick),
      .restart (restart),
      .active  (win_active),
      .done    (err_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   always_comb begin
      unique case (mode)
         PS_HUNT:  led_on = run_q & phase[0];
         PS_FEED:  led_on = run_q;
         PS_FAULT: led_on = run_q & win_active & phase[1];
         default:  led_on = 1'b0;
      endcase
   end
endmodule

// File: rtl/ledpat_gen_chk.sv
module ledpat_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       restart,
   input logic [1:0] port_state,
   input logic       led_on,
   input logic       err_done,
   input logic       run_q
);
   a_r1_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (port_state == 2'b00) |-> !led_on);

   a_r3_feed_lit: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && port_state == 2'b10) |-> led_on);

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      err_done |=> !err_done);

   a_r6_done_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
      err_done |-> ($past(port_state) == 2'b11 && $past(tick)));

   a_r7_restart_lit: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && port_state == 2'b01) |=> (led_on || port_state != 2'b01));

   a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && port_state == 2'b01 && $past(port_state) == 2'b01
       && !$past(tick) && !$past(restart)) |-> $stable(led_on));

   always @(negedge clk) begin
      if (!rst_n) a_r8_reset_dark: assert (!led_on);
   end
endmodule

bind ledpat_gen ledpat_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .restart    (restart),
   .port_state (port_state),
   .led_on     (led_on),
   .err_done   (err_done),
   .run_q      (run_q)
);

// File: tb/ledpat_gen_test.sv
module ledpat_gen_test;
   localparam int SLOW = 7;
   localparam int FAST = 3;
   localparam int WIN  = 20;
   localparam int NV   = 16;

   // vector: condition code, ticks after restart, expected lamp, expected done pulses
   localparam int VS [NV] = '{1, 1, 1, 1, 1, 2, 2, 0, 3, 3, 3, 3, 3, 3, 3, 0};
   localparam int VN [NV] = '{0, 6, 7, 13, 14, 0, 25, 5, 0, 2, 3, 6, 19, 20, 30, 0};
   localparam int VL [NV] = '{1, 1, 0, 0, 1, 1, 1, 0, 1, 1, 0, 1, 1, 0, 0, 0};
   localparam int VD [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       restart = 1'b0;
   logic [1:0] port_state = 2'b00;
   logic       led_on;
   logic       err_done;

   int checks = 0;
   int fails  = 0;
   int dones  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ledpat_gen #(.SLOW_HALF_MS(SLOW), .FAST_HALF_MS(FAST), .ERR_WINDOW_MS(WIN)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
      .port_state(port_state), .led_on(led_on), .err_done(err_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic go(input int st);
      @(negedge clk);
      port_state = st[1:0];
      restart = 1'b1;
      dones = 0;
      @(negedge clk);
      restart = 1'b0;
      if (err_done) dones++;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         if (err_done) dones++;
         @(negedge clk);
         tick = 1'b0;
         if (err_done) dones++;
      end
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (err_done) dones++;
      end
   endtask

   initial begin
      port_state = 2'b01;
      repeat (4) @(negedge clk);
      chk("R8 dark during reset", led_on, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 lit start after reset", led_on, 1);
      idle_cycles(5);
      chk("R9 steady without ticks", led_on, 1);

      for (int v = 0; v < NV; v++) begin
         go(VS[v]);
         ticks(VN[v]);
         idle_cycles(2);
         case (VS[v])
            0: chk("R1 idle lamp", led_on, VL[v]);
            1: chk("R2 hunting blink", led_on, VL[v]);
            2: chk("R3 feeding steady", led_on, VL[v]);
            default: chk((VN[v] >= WIN) ? "R5 window closed" : "R4 fault blink", led_on, VL[v]);
         endcase
         chk("R6 done pulse count", dones, VD[v]);
      end

      // R7: restart with same code mid-pattern
      go(1);
      ticks(8);
      chk("R2 dark after 8 ticks", led_on, 0);
      go(1);
      chk("R7 restart relights", led_on, 1);
      ticks(6);
      chk("R7 counts cleared", led_on, 1);

      // R7/R6: new window after restart of fault
      go(3);
      ticks(WIN);
      idle_cycles(3);
      chk("R6 first window done", dones, 1);
      go(3);
      chk("R7 fault restart relights", led_on, 1);
      ticks(WIN - 1);
      chk("R5 still open before last tick", led_on, (((WIN - 1) / FAST) % 2 == 0) ? 1 : 0);
      chk("R6 no early done", dones, 0);
      ticks(1);
      chk("R6 second window done", dones, 1);
      chk("R5 dark at window end", led_on, 0);

      // R1: idle ignores ticks
      go(0);
      ticks(9);
      chk("R1 idle ignores ticks", led_on, 0);

      // R8: reset mid-pattern
      go(1);
      ticks(SLOW);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 dark in reset", led_on, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 relit after reset", led_on, 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule